// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block links a synchronous host request port to an external asynchronous static RAM that holds 512K words of 8 bits. The host offers one access at a time. It raises `req` in a cycle where `ready` is high, and gives a 19-bit address, a write flag and write data with it. The controller then drives the memory strobes with registered outputs. It holds every phase for a whole number of clock cycles. Each count comes from a nanosecond minimum divided by the clock period and rounded up, and it is never less than one cycle.

A read lowers chip enable and output enable and keeps the strobes there until the slower of the access time and the cycle time has elapsed. The controller then samples the data pins and returns the byte with a one-cycle `rd_valid` pulse. A write lowers chip enable and write enable together, with output enable high and the controller's data driver on. It holds them for the longest of the pulse width, address setup, data setup and cycle time. Write enable, chip enable and the driver all release on the same clock edge. One or more idle turnaround cycles follow before any read can enable the memory's drivers. After reset the controller waits out the supply power-up delay before it accepts anything. Whenever it is idle it keeps chip enable high, so the memory stays in standby.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset is released, `ready` stays low and the memory strobes stay inactive (all high, driver off) for ceil(1000 ns / clock period) cycles. With the default 8 ns clock this is 125 cycles.
- R2: Each nanosecond minimum becomes ceil(ns / CLK_NS) cycles, with a floor of one. With the defaults, a read holds its strobes for 2 cycles, a write holds its strobes for 2 cycles, and the turnaround lasts 1 cycle (a 0 ns parameter).
- R3: A request with `req_we`=0 drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for the read phase length. The bus is sampled on the edge that ends the phase. The byte then appears on `rd_data` with `rd_valid` high for exactly one cycle, which is the first cycle in which `ready` is high again.
- R4: A request with `req_we`=1 drives `mem_ce_n`=0, `mem_we_n`=0 and `mem_oe_n`=1 for the write phase length, with the address and data on the pins. `mem_we_n` and `mem_ce_n` rise on the same edge.
- R5: `mem_dq_oe` is high only while `mem_we_n`=0, `mem_ce_n`=0 and `mem_oe_n`=1.
- R6: After a write ends, `mem_oe_n` stays high and the driver stays off for at least the turnaround length before a read can lower `mem_oe_n`.
- R7: `ready` goes low on the edge that accepts a request. It stays low for the read phase length after a read, and for the write phase length plus the turnaround length after a write.
- R8: A request presented while `ready` is low is ignored. It produces no memory strobe, no write and no `rd_valid`.
- R9: Whenever `ready` is high, `mem_ce_n` is high.
- R10: `mem_addr` does not change while `mem_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request strobe, taken when `ready` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| ready | output | 1 | High when a request can be accepted |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data driver toward the memory |
| mem_dq_in | input | 8 | Data from the memory pins |

## Verification
A phase counter that ends one cycle early makes the memory model return a wrong byte for the read, and the error shows up at `rd_data` in the `rd_valid` cycle. It also shortens the write-enable pulse, which the pin monitor measures on the edge where `mem_we_n` rises. If the state machine takes the wrong branch, `ready` comes back after the wrong number of cycles, or `mem_dq_oe` overlaps a low `mem_oe_n`, and this can be seen at the pins within the same access. If a write lands at the wrong address or is lost, nothing shows until the next read of that address. Random traffic over a small address pool keeps that delay to a few accesses.

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int AW         = 19,
  parameter int DW         = 8,
  parameter int CLK_NS     = 8,
  parameter int T_RC_NS    = 12,
  parameter int T_AA_NS    = 12,
  parameter int T_DOE_NS   = 6,
  parameter int T_WC_NS    = 12,
  parameter int T_PWE_NS   = 10,
  parameter int T_AW_NS    = 10,
  parameter int T_SD_NS    = 7,
  parameter int T_TURN_NS  = 0,
  parameter int T_PWRUP_NS = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          ready,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  function automatic int ns2cyc(input int ns);
    return (ns <= CLK_NS) ? 1 : (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC   = imax(imax(ns2cyc(T_RC_NS), ns2cyc(T_AA_NS)), ns2cyc(T_DOE_NS));
  localparam int WR_CYC   = imax(imax(ns2cyc(T_WC_NS), ns2cyc(T_PWE_NS)),
                                 imax(ns2cyc(T_AW_NS), ns2cyc(T_SD_NS)));
  localparam int TURN_CYC = ns2cyc(T_TURN_NS);
  localparam int PWR_CYC  = ns2cyc(T_PWRUP_NS);
  localparam int MAX_CYC  = imax(imax(RD_CYC, WR_CYC), imax(TURN_CYC, PWR_CYC));
  localparam int CW       = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {ST_PWR, ST_IDLE, ST_RD, ST_WR, ST_TURN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  wire           last = (cnt == '0);

  assign ready = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_PWR;
      cnt        <= CW'(PWR_CYC - 1);
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        ST_PWR: begin
          if (last) st <= ST_IDLE;
          else      cnt <= cnt - 1'b1;
        end
        ST_IDLE: begin
          if (req) begin
            mem_addr <= req_addr;
            mem_ce_n <= 1'b0;
            if (req_we) begin
              mem_we_n   <= 1'b0;
              mem_dq_oe  <= 1'b1;
              mem_dq_out <= req_wdata;
              cnt        <= CW'(WR_CYC - 1);
              st         <= ST_WR;
            end else begin
              mem_oe_n <= 1'b0;
              cnt      <= CW'(RD_CYC - 1);
              st       <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (last) begin
            rd_data  <= mem_dq_in;
            rd_valid <= 1'b1;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            st       <= ST_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        ST_WR: begin
          if (last) begin
            mem_we_n  <= 1'b1;
            mem_ce_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            cnt       <= CW'(TURN_CYC - 1);
            st        <= ST_TURN;
          end else cnt <= cnt - 1'b1;
        end
        ST_TURN: begin
          if (last) st <= ST_IDLE;
          else      cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> mem_ce_n) else $error("idle with chip enabled"); // R9
  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n && mem_oe_n)) else $error("driver on outside write"); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe) else $error("bus contention"); // R5
  AST_WRITE_END_JOINT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $rose(mem_ce_n)) else $error("write end split"); // R4
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> (mem_oe_n && !mem_dq_oe)) else $error("no turnaround"); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)) else $error("address moved"); // R10
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid) else $error("valid too long"); // R3
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req) |=> (!ready && !mem_ce_n)) else $error("accept failed"); // R7

endmodule

// File: tb/test_sram_seq_ctrl.sv
module test_sram_seq_ctrl;
  localparam int CLK_NS = 8;
  localparam int RD_CYC = 2;     // ceil(12/8) R2
  localparam int WR_CYC = 2;     // ceil(10/8), ceil(12/8) R2
  localparam int TURN_CYC = 1;   // 0 ns floored to 1 R2
  localparam int PWR_CYC = 125;  // ceil(1000/8) R1

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0] req_wdata = '0, rd_data, mem_dq_out, mem_dq_in = '0;
  logic rd_valid, ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [18:0] mem_addr;

  always #(CLK_NS/2) clk = ~clk;

  sram_seq_ctrl i_sram_seq_ctrl (
    .clk, .rst_n, .req, .req_we, .req_addr, .req_wdata, .rd_data, .rd_valid, .ready,
    .mem_ce_n, .mem_oe_n, .mem_we_n, .mem_addr, .mem_dq_out, .mem_dq_oe, .mem_dq_in);

  int n_chk = 0, n_fail = 0;
  logic [7:0] sram [int];
  logic [7:0] exp_mem [int];
  int wr_pulses = 0, wr_reqs = 0;
  bit mon_on = 1'b0;

  function automatic logic [7:0] init_val(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] sram_val(input logic [18:0] a);
    return sram.exists(int'(a)) ? sram[int'(a)] : init_val(a);
  endfunction
  function automatic logic [7:0] exp_val(input logic [18:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_val(a);
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, expv, $time);
    end
  endtask

  int rd_age = 0, wlen = 0, since_wend = 1000;
  logic p_we_n = 1'b1, p_ce_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0, p_valid = 1'b0;
  logic [18:0] p_addr = '0;
  logic [7:0] p_dq = '0;

  always @(negedge clk) if (mon_on) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age++; else rd_age = 0;
    mem_dq_in = (rd_age >= RD_CYC) ? sram_val(mem_addr) : ~sram_val(mem_addr);
    if (!mem_we_n) wlen++;
    if (!p_we_n && mem_we_n) begin
      wr_pulses++;
      if (!p_ce_n) sram[int'(p_addr)] = p_dq;
      check(wlen == WR_CYC, "R4 we pulse length", wlen, WR_CYC);
      check(mem_ce_n, "R4 ce with we end", mem_ce_n, 1);
      check(p_dq_oe && p_oe_n, "R5 driver during write", p_dq_oe, 1);
      wlen = 0;
      since_wend = 0;
    end else since_wend++;
    if (p_oe_n && !mem_oe_n)
      check(since_wend >= TURN_CYC + 1, "R6 turnaround gap", since_wend, TURN_CYC + 1);
    if (mem_dq_oe && (mem_we_n || !mem_oe_n))
      check(1'b0, "R5 driver outside write", mem_dq_oe, 0);
    if (ready && !mem_ce_n) check(1'b0, "R9 idle chip enable", mem_ce_n, 1);
    if (p_valid && rd_valid) check(1'b0, "R3 valid width", 2, 1);
    p_we_n = mem_we_n; p_ce_n = mem_ce_n; p_oe_n = mem_oe_n;
    p_dq_oe = mem_dq_oe; p_addr = mem_addr; p_dq = mem_dq_out; p_valid = rd_valid;
  end

  task automatic access(input bit we, input logic [18:0] a, input logic [7:0] d, input bit hold);
    int busy;
    while (!ready) @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (hold) begin
      req_we = 1'b1; req_addr = 19'h7FFF0; req_wdata = 8'h3C;
    end else req = 1'b0;
    busy = 0;
    while (!ready) begin busy++; @(negedge clk); end
    req = 1'b0;
    if (we) begin
      wr_reqs++;
      exp_mem[int'(a)] = d;
      check(busy == WR_CYC + TURN_CYC, "R7 write busy", busy, WR_CYC + TURN_CYC);
      check(wr_pulses == wr_reqs, "R8 write count", wr_pulses, wr_reqs);
    end else begin
      check(busy == RD_CYC, "R7 read busy", busy, RD_CYC);
      check(rd_valid == 1'b1, "R3 valid with ready", rd_valid, 1);
      check(rd_data == exp_val(a), "R3 read data", rd_data, exp_val(a));
      if (hold) check(wr_pulses == wr_reqs, "R8 ignored request", wr_pulses, wr_reqs);
    end
  endtask

  initial begin
    #(200000 * CLK_NS);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int low;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    check(!ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid,
          "R1 reset state", {ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b01110);
    rst_n = 1'b1;
    mon_on = 1'b1;
    low = 0;
    @(negedge clk);
    while (!ready) begin
      low++;
      if (!mem_ce_n || !mem_we_n) check(1'b0, "R1 strobe during power-up", 0, 1);
      @(negedge clk);
    end
    check(low == PWR_CYC - 1, "R1 power-up wait", low, PWR_CYC - 1);
    check(mem_ce_n, "R9 deselected when idle", mem_ce_n, 1);

    access(1'b0, 19'h00000, 8'h00, 1'b0);
    access(1'b1, 19'h00000, 8'h5A, 1'b0);
    access(1'b0, 19'h00000, 8'h00, 1'b0);
    access(1'b1, 19'h7FFFF, 8'hC3, 1'b0);
    access(1'b1, 19'h7FFFF, 8'h81, 1'b0);
    access(1'b0, 19'h7FFFF, 8'h00, 1'b0);
    access(1'b0, 19'h00001, 8'h00, 1'b1);
    access(1'b1, 19'h00002, 8'hF0, 1'b1);
    access(1'b0, 19'h7FFF0, 8'h00, 1'b0);
    access(1'b0, 19'h00002, 8'h00, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [18:0] a;
      case ($urandom % 4)
        0: a = 19'h7FFFF;
        1: a = 19'($urandom);
        default: a = 19'($urandom % 16);
      endcase
      access(1'($urandom % 2), a, 8'($urandom), ($urandom % 8) == 0);
    end
    @(negedge clk);
    @(negedge clk);
    check(!rd_valid && ready && mem_ce_n, "R9 quiet idle", {rd_valid, ready, mem_ce_n}, 3'b011);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule